// File: doc/BRIEF.md
# Chip Reset Sequencer with Start-up Timers

This block produces the internal chip reset for an entire device. It collects four kinds of reset request: a power-on detect, a brown-out detect, an external reset pin and a watchdog time-out. From these and a sleep indication it recognises six events. It holds `chip_rst` asserted from the time a request arrives until two start-up timers have run out after the request has gone away. The power-up timer counts ticks of a slow internal oscillator. The oscillator start-up timer counts edges of the external clock input. Each timer's done flag crosses into the main clock domain through two flops before it may end the reset.

A watchdog time-out while the device sleeps is a wake-up and not a reset. It leaves `chip_rst` low. For every event the block sets or clears two status flags, `flag_to` and `flag_pd`, so that software can tell what happened. It also drives a one-hot `cause` vector that holds its value until the next event. The voltage detectors, the oscillators and the watchdog counter are outside the block and reach it as digital inputs.

Top module: `chiprst_seq`

## Requirements
- R1: While `por_n` is low, `chip_rst` is 1, `cause` is 6'b000001 (bit 0, power-on), and `flag_to` and `flag_pd` are both 1.
- R2: A low level on `ext_rst_n` while `in_sleep` is 0 asserts `chip_rst` within 2 `clk` cycles. It sets `cause` to bit 1 (6'b000010) and leaves `flag_to` and `flag_pd` unchanged.
- R3: A low level on `ext_rst_n` while `in_sleep` is 1 asserts `chip_rst`. It sets `cause` to bit 2 (6'b000100), with `flag_to`=1 and `flag_pd`=0.
- R4: A one-cycle pulse on `wdt_to` while `in_sleep` is 0 and `chip_rst` is 0 asserts `chip_rst`. It sets `cause` to bit 3 (6'b001000), with `flag_to`=0 and `flag_pd`=1.
- R5: A pulse on `wdt_to` while `in_sleep` is 1 and `chip_rst` is 0 leaves `chip_rst` at 0. It sets `cause` to bit 4 (6'b010000) and clears both `flag_to` and `flag_pd`.
- R6: `bor_det` asserts `chip_rst` only when `bor_cfg_en` and `bor_sw_en` are both 1. In that case it sets `cause` to bit 5 (6'b100000) and sets both flags. With either enable at 0, `bor_det` changes neither `chip_rst`, `cause` nor the flags.
- R7: With `pwrt_en`=1, `chip_rst` stays asserted until 2048 rising edges of `lf_clk` have occurred after the last request ended, plus a synchronisation delay of at most 4 `clk` cycles.
- R8: With `ost_en`=1, `chip_rst` stays asserted until 1024 rising edges of `osc_in` have occurred after the last request ended, plus a synchronisation delay of at most 4 `clk` cycles.
- R9: A timer whose enable is 0 counts as expired. With both enables at 0, `chip_rst` falls no more than 4 `clk` cycles after the last request ends.
- R10: A new request that arrives while the timers are running restarts both timers from zero.
- R11: `cause` always has exactly one bit set, and it changes only when an event is recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous |
| lf_clk | input | 1 | Slow internal oscillator that clocks the power-up timer |
| osc_in | input | 1 | External oscillator input that clocks the start-up timer |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous to clk |
| wdt_to | input | 1 | Watchdog time-out pulse |
| in_sleep | input | 1 | Device is in sleep |
| bor_det | input | 1 | Brown-out detected |
| bor_cfg_en | input | 1 | Configuration enable for brown-out |
| bor_sw_en | input | 1 | Software enable for brown-out |
| pwrt_en | input | 1 | Power-up timer enable |
| ost_en | input | 1 | Oscillator start-up timer enable |
| chip_rst | output | 1 | Internal chip reset, active high |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |
| cause | output | 6 | One-hot cause of the last event |

## Verification
An event sorted into the wrong class shows up at the ports one clock after it is recognised: `cause` has the wrong bit set and the status flag pair does not match the expected one. A sleep wake-up that is wrongly treated as a reset raises `chip_rst`, which is visible two cycles after the pulse. A timer that runs short or long, a stale done flag left in the synchroniser, or a restart that fails to happen all move the falling edge of `chip_rst`. The bench tells these apart by sampling `chip_rst` shortly before and shortly after the expected release time, for each timer on its own and for both together.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NUM_EVT = 6;
  localparam int EV_POR       = 0;
  localparam int EV_EXT_RUN   = 1;
  localparam int EV_EXT_SLEEP = 2;
  localparam int EV_WDT_RUN   = 3;
  localparam int EV_WDT_WAKE  = 4;
  localparam int EV_BOR       = 5;

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  // Status pair {to, pd} after an event; cur is kept when the event leaves it alone
  function automatic logic [1:0] status_for(evt_vec_t ev, logic [1:0] cur);
    logic [1:0] r;
    r = cur;
    if (ev[EV_POR] || ev[EV_BOR]) r = 2'b11;
    else if (ev[EV_WDT_RUN])      r = 2'b01;
    else if (ev[EV_WDT_WAKE])     r = 2'b00;
    else if (ev[EV_EXT_SLEEP])    r = 2'b10;
    return r;
  endfunction
endpackage

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int WIDTH = 10
) (
  input  logic tclk,
  input  logic clr,
  output logic done
);
  localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge tclk or posedge clr) begin
    if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  // R7
  done_sticky_chk: assert property (@(posedge tclk) disable iff (clr) done |=> done);
endmodule

// File: rtl/done_sync.sv
module done_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic din,
  output logic dout
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      dout <= 1'b0;
    end else if (flush) begin
      meta <= 1'b0;
      dout <= 1'b0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/reset_classifier.sv
module reset_classifier
  import rstseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_lvl,
  input  logic     bor_lvl,
  input  logic     wdt_to,
  input  logic     in_sleep,
  input  logic     running,
  output evt_vec_t evt,
  output logic     wdt_rst_evt
);
  logic ext_prev, bor_prev;
  logic ext_edge, bor_edge, wdt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      bor_prev <= 1'b0;
    end else begin
      ext_prev <= ext_lvl;
      bor_prev <= bor_lvl;
    end
  end

  assign ext_edge = ext_lvl && !ext_prev;
  assign bor_edge = bor_lvl && !bor_prev;
  assign wdt_hit  = wdt_to && running;

  // Priority: brown-out over external pin over watchdog
  always_comb begin
    evt = '0;
    if (bor_edge)               evt[EV_BOR]       = 1'b1;
    else if (ext_edge)          evt[in_sleep ? EV_EXT_SLEEP : EV_EXT_RUN] = 1'b1;
    else if (wdt_hit)           evt[in_sleep ? EV_WDT_WAKE : EV_WDT_RUN]  = 1'b1;
  end

  assign wdt_rst_evt = evt[EV_WDT_RUN];

  // R11
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(evt));
endmodule

// File: rtl/chiprst_seq.sv
module chiprst_seq
  import rstseq_pkg::*;
#(
  parameter int OST_BITS  = 10,
  parameter int PWRT_BITS = 11
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lf_clk,
  input  logic       osc_in,
  input  logic       ext_rst_n,
  input  logic       wdt_to,
  input  logic       in_sleep,
  input  logic       bor_det,
  input  logic       bor_cfg_en,
  input  logic       bor_sw_en,
  input  logic       pwrt_en,
  input  logic       ost_en,
  output logic       chip_rst,
  output logic       flag_to,
  output logic       flag_pd,
  output logic [5:0] cause
);
  localparam evt_vec_t POR_CAUSE = evt_vec_t'(1) << EV_POR;

  logic     rst_q, tmr_clr;
  logic     ext_lvl, bor_lvl, wdt_rst_evt, req_any;
  evt_vec_t evt;
  logic     evt_valid;
  logic     ost_done, pwrt_done, ost_sync, pwrt_sync;
  logic     tmr_ok, release_now;
  logic [1:0] stat_q;

  assign ext_lvl = !ext_rst_n;
  assign bor_lvl = bor_det && bor_cfg_en && bor_sw_en;

  reset_classifier u_cls (
    .clk        (clk),
    .rst_n      (por_n),
    .ext_lvl    (ext_lvl),
    .bor_lvl    (bor_lvl),
    .wdt_to     (wdt_to),
    .in_sleep   (in_sleep),
    .running    (!rst_q),
    .evt        (evt),
    .wdt_rst_evt(wdt_rst_evt)
  );

  assign evt_valid = |evt;
  assign req_any   = ext_lvl || bor_lvl || wdt_rst_evt;

  // Counter clear is registered so the timers see a glitch-free asynchronous clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) tmr_clr <= 1'b1;
    else        tmr_clr <= req_any;
  end

  startup_timer #(.WIDTH(OST_BITS)) u_ost (
    .tclk(osc_in), .clr(tmr_clr), .done(ost_done)
  );
  startup_timer #(.WIDTH(PWRT_BITS)) u_pwrt (
    .tclk(lf_clk), .clr(tmr_clr), .done(pwrt_done)
  );

  done_sync u_ost_sync (
    .clk(clk), .rst_n(por_n), .flush(tmr_clr || req_any),
    .din(ost_done), .dout(ost_sync)
  );
  done_sync u_pwrt_sync (
    .clk(clk), .rst_n(por_n), .flush(tmr_clr || req_any),
    .din(pwrt_done), .dout(pwrt_sync)
  );

  assign tmr_ok      = (!ost_en || ost_sync) && (!pwrt_en || pwrt_sync);
  assign release_now = rst_q && !req_any && !tmr_clr && tmr_ok;

  // Set/clear hold latch
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           rst_q <= 1'b1;
    else if (req_any)     rst_q <= 1'b1;
    else if (release_now) rst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause  <= POR_CAUSE;
      stat_q <= status_for(POR_CAUSE, 2'b00);
    end else if (evt_valid) begin
      cause  <= evt;
      stat_q <= status_for(evt, stat_q);
    end
  end

  assign chip_rst = rst_q;
  assign flag_to  = stat_q[1];
  assign flag_pd  = stat_q[0];

  // R2
  req_sets_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    req_any |=> rst_q);
  // R5
  wake_no_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt[EV_WDT_WAKE] |=> !rst_q);
  // R9
  release_needs_timers_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> $past(tmr_ok) && !$past(req_any));
  // R2
  ext_run_keeps_flags_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt[EV_EXT_RUN] |=> $stable(stat_q));
  // R11
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause) == 1);
  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !evt_valid |=> $stable(cause));
endmodule

// File: tb/sim_chiprst_seq.sv
module sim_chiprst_seq;
  localparam int CLK_NS  = 10;
  localparam int LF_NS   = 40;
  localparam int OSC_NS  = 4;
  localparam int PWRT_NS = 2048 * LF_NS;
  localparam int OST_NS  = 1024 * OSC_NS;

  logic clk = 0, lf_clk = 0, osc_in = 0;
  logic por_n = 0, ext_rst_n = 1, wdt_to = 0, in_sleep = 0;
  logic bor_det = 0, bor_cfg_en = 1, bor_sw_en = 1;
  logic pwrt_en = 1, ost_en = 1;
  logic chip_rst, flag_to, flag_pd;
  logic [5:0] cause;
  int checks = 0, failures = 0;

  always #(CLK_NS/2) clk = ~clk;
  always #(LF_NS/2)  lf_clk = ~lf_clk;
  always #(OSC_NS/2) osc_in = ~osc_in;

  chiprst_seq u0 (
    .clk(clk), .por_n(por_n), .lf_clk(lf_clk), .osc_in(osc_in),
    .ext_rst_n(ext_rst_n), .wdt_to(wdt_to), .in_sleep(in_sleep),
    .bor_det(bor_det), .bor_cfg_en(bor_cfg_en), .bor_sw_en(bor_sw_en),
    .pwrt_en(pwrt_en), .ost_en(ost_en),
    .chip_rst(chip_rst), .flag_to(flag_to), .flag_pd(flag_pd), .cause(cause)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_state(input string req, input logic [5:0] c, input logic t, input logic p);
    chk(req, "cause", {2'b00, cause}, {2'b00, c});
    chk(req, "flag_to", {7'b0, flag_to}, {7'b0, t});
    chk(req, "flag_pd", {7'b0, flag_pd}, {7'b0, p});
  endtask

  task automatic ext_pulse();
    ext_rst_n = 0; cyc(3); ext_rst_n = 1;
  endtask

  task automatic wdt_pulse();
    wdt_to = 1; cyc(1); wdt_to = 0;
  endtask

  // Release check around a known timer length
  task automatic chk_release(input string req, input int len_ns);
    #(len_ns - len_ns/8);
    @(negedge clk);
    chk(req, "held before expiry", {7'b0, chip_rst}, 8'd1);
    #(len_ns/8 + len_ns/8);
    @(negedge clk);
    chk(req, "released after expiry", {7'b0, chip_rst}, 8'd0);
  endtask

  task automatic t_por();
    cyc(5);
    chk("R1", "chip_rst", {7'b0, chip_rst}, 8'd1);
    chk_state("R1", 6'b000001, 1, 1);
    por_n = 1;
    chk_release("R7", PWRT_NS);
    chk_state("R1", 6'b000001, 1, 1);
  endtask

  task automatic t_wdt_run();
    pwrt_en = 0;
    wdt_pulse(); cyc(1);
    chk("R4", "chip_rst", {7'b0, chip_rst}, 8'd1);
    chk_state("R4", 6'b001000, 0, 1);
    chk_release("R8", OST_NS);
  endtask

  task automatic t_ext_run();
    ext_pulse(); cyc(1);
    chk("R2", "chip_rst", {7'b0, chip_rst}, 8'd1);
    chk_state("R2", 6'b000010, 0, 1);
    chk_release("R8", OST_NS);
  endtask

  task automatic t_wake();
    in_sleep = 1;
    wdt_pulse(); cyc(1);
    chk("R5", "chip_rst", {7'b0, chip_rst}, 8'd0);
    chk_state("R5", 6'b010000, 0, 0);
    cyc(5);
    chk("R5", "chip_rst later", {7'b0, chip_rst}, 8'd0);
  endtask

  task automatic t_ext_sleep();
    ext_pulse(); cyc(1);
    in_sleep = 0;
    chk("R3", "chip_rst", {7'b0, chip_rst}, 8'd1);
    chk_state("R3", 6'b000100, 1, 0);
    chk_release("R8", OST_NS);
  endtask

  task automatic t_bor();
    bor_sw_en = 0; bor_det = 1; cyc(6);
    chk("R6", "gated sw chip_rst", {7'b0, chip_rst}, 8'd0);
    chk_state("R6", 6'b000100, 1, 0);
    bor_det = 0; bor_sw_en = 1; bor_cfg_en = 0; cyc(2);
    bor_det = 1; cyc(6);
    chk("R6", "gated cfg chip_rst", {7'b0, chip_rst}, 8'd0);
    chk_state("R6", 6'b000100, 1, 0);
    bor_det = 0; bor_cfg_en = 1; cyc(2);
    bor_det = 1; cyc(3); bor_det = 0; cyc(1);
    chk("R6", "enabled chip_rst", {7'b0, chip_rst}, 8'd1);
    chk_state("R6", 6'b100000, 1, 1);
    chk_release("R8", OST_NS);
  endtask

  task automatic t_both_off();
    ost_en = 0; pwrt_en = 0;
    ext_pulse(); cyc(4);
    chk("R9", "released fast", {7'b0, chip_rst}, 8'd0);
    ost_en = 1; pwrt_en = 0;
  endtask

  task automatic t_restart();
    pwrt_en = 1;
    ext_pulse();
    #(PWRT_NS/2);
    @(negedge clk);
    chk("R10", "held mid-count", {7'b0, chip_rst}, 8'd1);
    ext_pulse();
    chk_release("R10", PWRT_NS);
  endtask

  initial begin
    fork
      begin
        t_por(); t_wdt_run(); t_ext_run(); t_wake(); t_ext_sleep();
        t_bor(); t_both_off(); t_restart();
      end
      begin
        #(1000000);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule